// File: doc/BRIEF.md
# Power-Up and Brown-Out Reset Sequencer

This block generates the internal reset of a small microcontroller core. Four events can force the core into reset: a low level on the active-low master-clear pin, a power-on detect pulse, a qualified supply brown-out, and a watchdog timeout while the core is running. Reset is held for as long as a level-type cause (master clear, or a low supply) persists. When every cause has cleared, reset stays asserted while the block runs a power-up delay, which a configuration bit can enable. If a second configuration bit selects a crystal-type oscillator, an oscillator start-up wait follows the delay. Only then is reset released.

The power-up delay counts a slow tick input. With a 10 µs tick the default of 7200 ticks gives about 72 ms. The start-up wait counts a separate oscillator-cycle enable input, 1024 cycles by default. The supply-good comparator output is filtered on the same tick. A dip must last a set number of ticks, 100 µs by default, before it counts as a brown-out, so shorter glitches are ignored. A qualified brown-out that occurs during the power-up delay sends the block back to the hold state, and the full delay then starts over once the supply returns. A two-bit field reports the most recent reset cause. A one-cycle pulse tells the core to begin fetching at address zero.

Top module: `rst_sequencer`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `core_rst_o` is 1 and `cause_o` is 0. The cause codes are 0 = power-on, 1 = master clear, 2 = watchdog, 3 = brown-out.
- R2: If `mclr_n_i` is sampled low (and there is no power-on pulse), `core_rst_o` is 1 after the next clock edge and `cause_o` becomes 1. Reset stays asserted for as long as the pin stays low.
- R3: Take edge E as the clock edge at which every hold cause has cleared and the block leaves its hold state. With both configuration bits set, `core_rst_o` falls at edge E + PWRT_TICKS + OST_CYCLES. This assumes the tick and oscillator enables are high on every cycle.
- R4: With `cfg_pwrt_en_i` = 0, the power-up delay is skipped and `core_rst_o` falls at edge E + OST_CYCLES.
- R5: With `cfg_ost_en_i` = 0, the start-up wait is skipped and `core_rst_o` falls at edge E + PWRT_TICKS.
- R6: If `supply_ok_i` is low for BOR_TICKS consecutive ticks, reset is asserted one edge later with `cause_o` = 3. Reset is held while the supply stays low. The hold state is left on the second edge after the supply recovers.
- R7: A supply dip shorter than BOR_TICKS ticks leaves `core_rst_o` and `cause_o` unchanged.
- R8: A qualified brown-out during the power-up delay returns the block to hold. After the supply recovers, the full delay runs again from the start.
- R9: A watchdog timeout pulse while `core_rst_o` is 0 asserts reset after the next edge with `cause_o` = 2. A timeout pulse while reset is asserted changes neither the cause nor the release time.
- R10: A power-on pulse forces reset from any state and sets `cause_o` to 0. No other event writes code 0.
- R11: When several causes occur in the same cycle, the recorded cause follows the priority power-on > master clear > brown-out > watchdog.
- R12: `boot_o` is high for exactly the first cycle in which `core_rst_o` is 0. This is the cue for the core to load its program counter with 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low register reset |
| mclr_n_i | input | 1 | Master-clear pin, active low |
| supply_ok_i | input | 1 | Supply comparator output, 1 when the supply is above threshold |
| por_pulse_i | input | 1 | Power-on detect pulse |
| wdt_timeout_i | input | 1 | Watchdog timeout pulse |
| tick_i | input | 1 | Slow timing tick enable |
| osc_tick_i | input | 1 | One pulse per oscillator cycle |
| cfg_pwrt_en_i | input | 1 | Enables the power-up delay |
| cfg_ost_en_i | input | 1 | Crystal-type oscillator: enables the start-up wait |
| core_rst_o | output | 1 | Reset to the core, active high |
| cause_o | output | 2 | Most recent reset cause (encoding in R1) |
| boot_o | output | 1 | One-cycle start-of-execution pulse |

## Verification
The bench measures the reset release to the exact edge after power-on, master clear, watchdog and brown-out recovery. A counter that is off by one, or that does not restart, moves the falling edge and is caught.

It drives a supply dip one tick shorter than the qualification window, which a filter without a proper threshold would turn into a spurious brown-out. It also drops the supply midway through the power-up delay; a design that resumed its count instead of restarting would release reset early. Finally, it fires a watchdog pulse during the delay and applies coincident causes. A design that lets the watchdog act outside normal operation, or that gets the priority wrong, would report the wrong cause code.

// File: rtl/rst_sequencer_pkg.sv
// Package: shared types of the reset sequencer.
// Assumes: two-bit encodings; the cause values are visible at the top port.
package rst_sequencer_pkg;

    typedef enum logic [1:0] {
        SEQ_HOLD = 2'd0,
        SEQ_PWRT = 2'd1,
        SEQ_OST  = 2'd2,
        SEQ_RUN  = 2'd3
    } seq_state_t;

    typedef enum logic [1:0] {
        CAUSE_POR  = 2'd0,
        CAUSE_MCLR = 2'd1,
        CAUSE_WDT  = 2'd2,
        CAUSE_BOR  = 2'd3
    } rst_cause_t;

endpackage

// File: rtl/rst_seq_interval.sv
// Interval counter: counts step pulses while run_i is high and pulses done_o
// on the step that completes LIMIT steps. It clears whenever run_i is low.
// Assumes: LIMIT >= 2; the caller drops run_i after done_o.
module rst_seq_interval #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic step_i,
    output logic done_o
);
    localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_q;

    // Count step pulses inside the active window.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q <= '0;
        end else if (step_i && cnt_q != LAST) begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    // Flag the step that completes the interval.
    always_comb begin
        done_o = run_i && step_i && (cnt_q == LAST);
    end
endmodule

// File: rtl/rst_seq_dip_filter.sv
// Supply dip filter: raises brownout_o once supply_ok_i has been low for
// QUAL_TICKS ticks in a row, and drops it on the first cycle the supply is good.
// Assumes: QUAL_TICKS >= 2; the supply input is already synchronous.
module rst_seq_dip_filter #(
    parameter int QUAL_TICKS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok_i,
    input  logic tick_i,
    output logic brownout_o
);
    localparam int W = (QUAL_TICKS > 1) ? $clog2(QUAL_TICKS) : 1;
    localparam logic [W-1:0] LAST = W'(QUAL_TICKS - 1);

    logic [W-1:0] low_cnt_q;
    logic         bo_q;

    // Measure the length of the current dip and qualify it.
    always_ff @(posedge clk) begin
        if (!rst_n || supply_ok_i) begin
            low_cnt_q <= '0;
            bo_q      <= 1'b0;
        end else if (tick_i && !bo_q) begin
            if (low_cnt_q == LAST) begin
                bo_q <= 1'b1;
            end else begin
                low_cnt_q <= low_cnt_q + W'(1);
            end
        end
    end

    assign brownout_o = bo_q;
endmodule

// File: rtl/rst_seq_cause.sv
// Cause recorder: keeps the most recent reset cause and applies a fixed
// priority when causes coincide. Only a power-on event writes the power-on code.
// Assumes: inputs are already qualified (the watchdog only while running).
module rst_seq_cause
    import rst_sequencer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       por_i,
    input  logic       mclr_i,
    input  logic       bor_i,
    input  logic       wdt_i,
    output rst_cause_t cause_o
);
    rst_cause_t cause_q;

    // Latch the highest-priority active cause.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= CAUSE_POR;
        end else if (por_i) begin
            cause_q <= CAUSE_POR;
        end else if (mclr_i) begin
            cause_q <= CAUSE_MCLR;
        end else if (bor_i) begin
            cause_q <= CAUSE_BOR;
        end else if (wdt_i) begin
            cause_q <= CAUSE_WDT;
        end
    end

    assign cause_o = cause_q;
endmodule

// File: rtl/rst_sequencer.sv
// Reset sequencer top. It holds the core in reset while any cause is active,
// then chains the optional power-up delay and the optional oscillator start-up
// wait before releasing reset and issuing a one-cycle boot pulse.
// Assumes: all inputs are synchronous to clk; tick_i and osc_tick_i are enables.
module rst_sequencer
    import rst_sequencer_pkg::*;
#(
    parameter int PWRT_TICKS = 7200,
    parameter int OST_CYCLES = 1024,
    parameter int BOR_TICKS  = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mclr_n_i,
    input  logic       supply_ok_i,
    input  logic       por_pulse_i,
    input  logic       wdt_timeout_i,
    input  logic       tick_i,
    input  logic       osc_tick_i,
    input  logic       cfg_pwrt_en_i,
    input  logic       cfg_ost_en_i,
    output logic       core_rst_o,
    output logic [1:0] cause_o,
    output logic       boot_o
);
    seq_state_t state_q, state_n;
    rst_cause_t cause_w;
    logic       brownout;
    logic       wdt_live;
    logic       hold_req;
    logic       pwrt_done;
    logic       ost_done;
    logic       boot_q;

    // Qualify supply dips into brown-out events.
    rst_seq_dip_filter #(.QUAL_TICKS(BOR_TICKS)) u_dip (
        .clk        (clk),
        .rst_n      (rst_n),
        .supply_ok_i(supply_ok_i),
        .tick_i     (tick_i),
        .brownout_o (brownout)
    );

    // Power-up delay on the slow tick.
    rst_seq_interval #(.LIMIT(PWRT_TICKS)) u_pwrt (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (state_q == SEQ_PWRT),
        .step_i(tick_i),
        .done_o(pwrt_done)
    );

    // Oscillator start-up wait on oscillator cycles.
    rst_seq_interval #(.LIMIT(OST_CYCLES)) u_ost (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (state_q == SEQ_OST),
        .step_i(osc_tick_i),
        .done_o(ost_done)
    );

    // Record the last reset cause.
    rst_seq_cause u_cause (
        .clk    (clk),
        .rst_n  (rst_n),
        .por_i  (por_pulse_i),
        .mclr_i (!mclr_n_i),
        .bor_i  (brownout),
        .wdt_i  (wdt_live),
        .cause_o(cause_w)
    );

    // Watchdog acts only during normal operation; any cause requests hold.
    always_comb begin
        wdt_live = wdt_timeout_i && (state_q == SEQ_RUN);
        hold_req = por_pulse_i || !mclr_n_i || brownout || wdt_live;
    end

    // Sequence: hold -> power-up delay -> start-up wait -> run.
    always_comb begin
        state_n = state_q;
        if (hold_req) begin
            state_n = SEQ_HOLD;
        end else begin
            unique case (state_q)
                SEQ_HOLD: begin
                    if (cfg_pwrt_en_i)     state_n = SEQ_PWRT;
                    else if (cfg_ost_en_i) state_n = SEQ_OST;
                    else                   state_n = SEQ_RUN;
                end
                SEQ_PWRT: begin
                    if (pwrt_done) state_n = cfg_ost_en_i ? SEQ_OST : SEQ_RUN;
                end
                SEQ_OST: begin
                    if (ost_done) state_n = SEQ_RUN;
                end
                SEQ_RUN: state_n = SEQ_RUN;
                default: state_n = SEQ_HOLD;
            endcase
        end
    end

    // State register and boot pulse on entry to run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_HOLD;
            boot_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            boot_q  <= (state_n == SEQ_RUN) && (state_q != SEQ_RUN);
        end
    end

    assign core_rst_o = (state_q != SEQ_RUN);
    assign cause_o    = cause_w;
    assign boot_o     = boot_q;
endmodule

// File: rtl/rst_sequencer_chk.sv
// Checker for the reset sequencer: port-level properties bound to the top.
// Assumes: the cause encoding of the package.
module rst_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mclr_n_i,
    input logic       por_pulse_i,
    input logic       wdt_timeout_i,
    input logic       core_rst_o,
    input logic [1:0] cause_o,
    input logic       boot_o
);
    // R2: master clear forces reset and records its code.
    a_r2_mclr_forces: assert property (@(posedge clk) disable iff (!rst_n)
        (!mclr_n_i && !por_pulse_i) |=> (core_rst_o && cause_o == 2'd1));

    // R10: power-on pulse forces reset with code 0.
    a_r10_por_forces: assert property (@(posedge clk) disable iff (!rst_n)
        por_pulse_i |=> (core_rst_o && cause_o == 2'd0));

    // R9: watchdog during run asserts reset.
    a_r9_wdt_resets: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_timeout_i && !core_rst_o) |=> core_rst_o);

    // R12: boot pulse lasts one cycle.
    a_r12_boot_single: assert property (@(posedge clk) disable iff (!rst_n)
        boot_o |=> !boot_o);

    // R12: boot pulse marks the release of reset.
    a_r12_boot_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        boot_o |-> (!core_rst_o && $past(core_rst_o)));
endmodule

bind rst_sequencer rst_sequencer_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mclr_n_i     (mclr_n_i),
    .por_pulse_i  (por_pulse_i),
    .wdt_timeout_i(wdt_timeout_i),
    .core_rst_o   (core_rst_o),
    .cause_o      (cause_o),
    .boot_o       (boot_o)
);

// File: tb/rst_sequencer_tb.sv
`timescale 1ns/100ps
// Scoreboard bench: the driver pushes expectations, the monitor compares them.
module rst_sequencer_tb;
    localparam int PWRT = 8;
    localparam int OST  = 5;
    localparam int BOR  = 3;

    logic       clk = 1'b0;
    logic       rst_n, mclr_n, supply_ok, por, wdt, pwrt_en, ost_en;
    logic       core_rst, boot;
    logic [1:0] cause;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    logic  q_rst[$];
    int    q_cause[$];
    int    q_boot[$];
    string q_tag[$];

    always #2.5 clk = ~clk;

    rst_sequencer #(.PWRT_TICKS(PWRT), .OST_CYCLES(OST), .BOR_TICKS(BOR)) u_dut (
        .clk(clk), .rst_n(rst_n), .mclr_n_i(mclr_n), .supply_ok_i(supply_ok),
        .por_pulse_i(por), .wdt_timeout_i(wdt), .tick_i(1'b1), .osc_tick_i(1'b1),
        .cfg_pwrt_en_i(pwrt_en), .cfg_ost_en_i(ost_en),
        .core_rst_o(core_rst), .cause_o(cause), .boot_o(boot)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // cause / boot of -1 means do not compare
    task automatic expect_out(input logic r, input int c, input int b, input string tag);
        q_rst.push_back(r);
        q_cause.push_back(c);
        q_boot.push_back(b);
        q_tag.push_back(tag);
    endtask

    // Monitor: pop and compare just after each falling edge.
    always begin
        @(negedge clk);
        #1;
        while (q_tag.size() > 0) begin
            logic  r;
            int    c, b;
            string t;
            r = q_rst.pop_front();
            c = q_cause.pop_front();
            b = q_boot.pop_front();
            t = q_tag.pop_front();
            checks++;
            if (core_rst !== r) begin
                errors++;
                $display("FAIL %s core_rst actual %0b expected %0b", t, core_rst, r);
            end else if (c >= 0 && int'(cause) != c) begin
                errors++;
                $display("FAIL %s cause actual %0d expected %0d", t, cause, c);
            end else if (b >= 0 && int'(boot) != b) begin
                errors++;
                $display("FAIL %s boot actual %0b expected %0d", t, boot, b);
            end
        end
    end

    // Watchdog for a hung run.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; mclr_n = 1; supply_ok = 1; por = 0; wdt = 0;
        pwrt_en = 1; ost_en = 1;
        step(3);
        expect_out(1'b1, 0, 0, "R1 reset state");
        rst_n = 1;
        step(1);
        expect_out(1'b1, 0, 0, "R1 first cycle after reset");
        // R3: full chain, release at edge 14
        step(12);
        expect_out(1'b1, 0, -1, "R3 still held before delay ends");
        step(1);
        expect_out(1'b0, 0, 1, "R3 R12 release with boot pulse");
        step(1);
        expect_out(1'b0, 0, 0, "R12 boot pulse one cycle");

        // R7: short dip ignored
        supply_ok = 0; step(BOR - 1); supply_ok = 1;
        step(3);
        expect_out(1'b0, 0, -1, "R7 short dip ignored");

        // R9: watchdog in run
        wdt = 1; step(1); wdt = 0;
        expect_out(1'b1, 2, -1, "R9 watchdog reset");
        step(13);
        expect_out(1'b1, 2, -1, "R9 R3 held after watchdog");
        step(1);
        expect_out(1'b0, 2, -1, "R9 R3 release after watchdog");

        // R2: master clear, watchdog ignored during delay
        mclr_n = 0; step(1);
        expect_out(1'b1, 1, -1, "R2 master clear reset");
        step(4);
        expect_out(1'b1, 1, -1, "R2 held while pin low");
        mclr_n = 1;
        step(3);
        wdt = 1; step(1); wdt = 0;
        expect_out(1'b1, 1, -1, "R9 watchdog ignored in reset");
        step(9);
        expect_out(1'b1, 1, -1, "R9 delay not restarted, still held");
        step(1);
        expect_out(1'b0, 1, -1, "R9 delay not restarted, release");

        // R11: coincident causes
        mclr_n = 0; wdt = 1; step(1); wdt = 0;
        expect_out(1'b1, 1, -1, "R11 master clear over watchdog");
        por = 1; step(1); por = 0;
        expect_out(1'b1, 0, -1, "R11 R10 power-on over master clear");
        mclr_n = 1;
        step(14);
        expect_out(1'b0, 0, -1, "R10 release after power-on");

        // R6: qualified brown-out
        supply_ok = 0; step(BOR);
        expect_out(1'b0, 0, -1, "R6 not yet in reset while qualifying");
        step(1);
        expect_out(1'b1, 3, -1, "R6 brown-out reset");
        step(10);
        expect_out(1'b1, 3, -1, "R6 held while supply low");
        supply_ok = 1;
        step(6);
        // R8: drop during delay restarts it
        supply_ok = 0; step(BOR + 1);
        expect_out(1'b1, 3, -1, "R8 brown-out during delay");
        supply_ok = 1;
        step(14);
        expect_out(1'b1, 3, -1, "R8 full delay rerun, still held");
        step(1);
        expect_out(1'b0, 3, -1, "R8 release after full delay");

        // R4: power-up delay disabled
        pwrt_en = 0;
        por = 1; step(1); por = 0;
        expect_out(1'b1, 0, -1, "R4 power-on reset");
        step(5);
        expect_out(1'b1, 0, -1, "R4 held during start-up wait");
        step(1);
        expect_out(1'b0, 0, 1, "R4 release without delay");

        // R5: start-up wait disabled
        pwrt_en = 1; ost_en = 0;
        por = 1; step(1); por = 0;
        expect_out(1'b1, 0, -1, "R5 power-on reset");
        step(8);
        expect_out(1'b1, 0, -1, "R5 held during delay");
        step(1);
        expect_out(1'b0, 0, 1, "R5 release without start-up wait");

        step(2);
        done_flag = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule